// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is a synthesizable behavioural model of the command decoder of a byte-wide NOR flash die. It watches single-cycle write strobes on an address/data bus and recognises the unlock-and-command sequences for byte program, sector erase and whole-array erase. A recognised command starts a shortened embedded-algorithm timer. The timer holds an open-drain ready/busy line low for a set number of clock cycles. At the end of that run, the operation is committed to a small register array.

Reads are single-cycle strobes. While an operation runs, a read that targets the busy region returns a polling status byte instead of array data. The status byte carries the complement of the pending data's top bit and a toggling bit. During a sector erase, reads of any other sector still return array data. Busy durations are parameters, so a system model or testbench can use short program and erase times. The array is scaled down: each of the 32 sectors holds only a few bytes. Programming can only clear bits, and erasing sets bytes to FFh.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, `ry_by_n` is released (high impedance) and `rdata` is 00h. The decoder is in read mode, so a read returns array contents.
- R2: The program sequence is four writes: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then data to the target address. It stores old AND data at the target byte. Command addresses compare address bits [14:0]. The sector is address bits [15:11] and the byte within the sector is bits [1:0].
- R3: `ry_by_n` is driven 0 for exactly PROG_CYCLES clock cycles for a program, SECT_CYCLES cycles for a sector erase and CHIP_CYCLES cycles for a whole-array erase. The low period starts on the edge that accepts the final write. At all other times the line is released.
- R4: `rdata` is loaded on the clock edge that samples `rd_en`. While a program runs, any read returns the status byte: bit 7 = NOT data[7], bit 6 = toggle, bits 5:0 = 0. After completion, a read of the target returns the true stored byte.
- R5: Bit 6 of the status byte is 0 on the first status read after an operation starts and inverts on every later status read of that operation.
- R6: The sector erase sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h to any address inside the target sector. It sets every byte of that sector to FFh and leaves other sectors unchanged.
- R7: The same sequence ending in 10h@5555h sets every byte of the array to FFh.
- R8: During a sector erase, reads of another sector return array data. Reads inside the erasing sector return the status byte, whose bit 7 is 0.
- R9: A write that breaks an expected sequence returns the decoder to read mode without touching the array. A following data write does not program, and a complete sequence afterwards works normally.
- R10: Writes accepted while busy are ignored: they neither start an operation nor advance the decoder.
- R11: Asserting `rst_n` low during an operation aborts it: the line is released, the target byte keeps its old value and the decoder returns to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Read data, registered |
| ry_by_n | output | 1 | Open-drain ready/busy: 0 while busy, high impedance when ready |

## Verification
The checker watches the timer handshake on every cycle. A decoded start always raises busy on the next cycle, and no start can occur while busy. Busy stays up until the timer's done cycle and then drops. On every cycle it also checks the status reads: bits 5:0 are zero, bit 7 is the complement of the captured data bit, and bit 6 starts at 0 and alternates. Only the directed scenarios can show the array effects: AND-merging, sector versus whole-array erase, reads of other sectors during an erase, broken sequences, ignored writes and reset aborts. The exact busy lengths seen on the open-drain pin are also checked only there.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2
  } op_kind_e;

  typedef enum logic [2:0] {
    SQ_READ  = 3'd0,
    SQ_UNL1  = 3'd1,
    SQ_UNL2  = 3'd2,
    SQ_PDATA = 3'd3,
    SQ_ERS1  = 3'd4,
    SQ_ERS2  = 3'd5,
    SQ_ERS3  = 3'd6
  } seq_state_e;

  localparam logic [7:0] CB_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CB_UNLOCK_B = 8'h55;
  localparam logic [7:0] CB_PROGRAM  = 8'hA0;
  localparam logic [7:0] CB_ERASE    = 8'h80;
  localparam logic [7:0] CB_CHIP     = 8'h10;
  localparam logic [7:0] CB_SECTOR   = 8'h30;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // Programming can only pull bits to zero.
  function automatic logic [7:0] merge_program(input logic [7:0] old_b,
                                               input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Status byte returned to a poller while an operation is running.
  function automatic logic [7:0] poll_byte(input logic [7:0] pend,
                                           input logic tog);
    return {~pend[7], tog, 6'b000000};
  endfunction

endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int CMD_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                busy,
  input  logic [CMD_BITS-1:0] cmd_addr,
  input  logic [7:0]          wdata,
  output logic                start_op,
  output op_kind_e            start_kind
);

  localparam logic [CMD_BITS-1:0] ADR_A = CMD_BITS'(16'h5555);
  localparam logic [CMD_BITS-1:0] ADR_B = CMD_BITS'(16'h2AAA);

  seq_state_e st_q, st_d;
  logic       take;
  logic       at_a, at_b;

  assign take = wr_en && !busy;
  assign at_a = (cmd_addr == ADR_A);
  assign at_b = (cmd_addr == ADR_B);

  always_comb begin
    st_d       = st_q;
    start_op   = 1'b0;
    start_kind = OP_PROG;
    if (take) begin
      st_d = SQ_READ;
      unique case (st_q)
        SQ_READ:  if (at_a && wdata == CB_UNLOCK_A) st_d = SQ_UNL1;
        SQ_UNL1:  if (at_b && wdata == CB_UNLOCK_B) st_d = SQ_UNL2;
        SQ_UNL2: begin
          if (at_a && wdata == CB_PROGRAM)    st_d = SQ_PDATA;
          else if (at_a && wdata == CB_ERASE) st_d = SQ_ERS1;
        end
        SQ_PDATA: begin
          start_op   = 1'b1;
          start_kind = OP_PROG;
        end
        SQ_ERS1:  if (at_a && wdata == CB_UNLOCK_A) st_d = SQ_ERS2;
        SQ_ERS2:  if (at_b && wdata == CB_UNLOCK_B) st_d = SQ_ERS3;
        SQ_ERS3: begin
          if (at_a && wdata == CB_CHIP) begin
            start_op   = 1'b1;
            start_kind = OP_CHIP;
          end else if (wdata == CB_SECTOR) begin
            start_op   = 1'b1;
            start_kind = OP_SECT;
          end
        end
        default: st_d = SQ_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_READ;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_len,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] remain
);

  assign done = busy && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= load_len - CNT_W'(1);
    end else if (done) begin
      busy   <= 1'b0;
    end else if (busy) begin
      remain <= remain - CNT_W'(1);
    end
  end

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_cmd_pkg::*;
#(
  parameter int SECT_BITS = 5,
  parameter int OFF_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 commit,
  input  op_kind_e             kind,
  input  logic [SECT_BITS-1:0] tgt_sect,
  input  logic [OFF_BITS-1:0]  tgt_off,
  input  logic [7:0]           tgt_data,
  input  logic [SECT_BITS-1:0] rd_sect,
  input  logic [OFF_BITS-1:0]  rd_off,
  output logic [7:0]           rd_byte
);

  localparam int SECTORS = 1 << SECT_BITS;
  localparam int ROW_N   = 1 << OFF_BITS;

  logic [7:0] sect_rd [SECTORS];

  for (genvar g = 0; g < SECTORS; g++) begin : g_sect
    logic [7:0] row [ROW_N];
    logic       wipe, prog;

    assign wipe = commit && (kind == OP_CHIP ||
                  (kind == OP_SECT && tgt_sect == SECT_BITS'(g)));
    assign prog = commit && kind == OP_PROG && tgt_sect == SECT_BITS'(g);

    always_ff @(posedge clk) begin
      for (int j = 0; j < ROW_N; j++) begin
        if (wipe)
          row[j] <= ERASED_BYTE;
        else if (prog && tgt_off == OFF_BITS'(j))
          row[j] <= merge_program(row[j], tgt_data);
      end
    end

    assign sect_rd[g] = row[rd_off];
  end

  assign rd_byte = sect_rd[rd_sect];

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CMD_BITS    = 15,
  parameter int SECT_BITS   = 5,
  parameter int OFF_BITS    = 2,
  parameter int PROG_CYCLES = 8,
  parameter int SECT_CYCLES = 20,
  parameter int CHIP_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ry_by_n
);

  localparam int MAX_CYC = (PROG_CYCLES > SECT_CYCLES) ?
                           ((PROG_CYCLES > CHIP_CYCLES) ? PROG_CYCLES : CHIP_CYCLES) :
                           ((SECT_CYCLES > CHIP_CYCLES) ? SECT_CYCLES : CHIP_CYCLES);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  function automatic logic [CNT_W-1:0] op_length(input op_kind_e k);
    unique case (k)
      OP_PROG: return CNT_W'(PROG_CYCLES);
      OP_SECT: return CNT_W'(SECT_CYCLES);
      default: return CNT_W'(CHIP_CYCLES);
    endcase
  endfunction

  // Named internal events, also used by the bound checker.
  logic             start_op;
  op_kind_e         start_kind;
  logic             busy;
  logic             done;
  logic [CNT_W-1:0] remain;
  logic             rd_status;
  logic             toggle_q;

  op_kind_e              kind_q;
  logic [SECT_BITS-1:0]  sect_q;
  logic [OFF_BITS-1:0]   off_q;
  logic [7:0]            pend_q;
  logic [SECT_BITS-1:0]  rd_sect;
  logic [7:0]            arr_byte;

  assign rd_sect = addr[ADDR_W-1 -: SECT_BITS];

  flash_seq_decoder #(.CMD_BITS(CMD_BITS)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .busy       (busy),
    .cmd_addr   (addr[CMD_BITS-1:0]),
    .wdata      (wdata),
    .start_op   (start_op),
    .start_kind (start_kind)
  );

  flash_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_op),
    .load_len (op_length(start_kind)),
    .busy     (busy),
    .done     (done),
    .remain   (remain)
  );

  flash_byte_array #(.SECT_BITS(SECT_BITS), .OFF_BITS(OFF_BITS)) u_arr (
    .clk      (clk),
    .commit   (done),
    .kind     (kind_q),
    .tgt_sect (sect_q),
    .tgt_off  (off_q),
    .tgt_data (pend_q),
    .rd_sect  (rd_sect),
    .rd_off   (addr[OFF_BITS-1:0]),
    .rd_byte  (arr_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_PROG;
      sect_q <= '0;
      off_q  <= '0;
      pend_q <= ERASED_BYTE;
    end else if (start_op) begin
      kind_q <= start_kind;
      sect_q <= rd_sect;
      off_q  <= addr[OFF_BITS-1:0];
      pend_q <= (start_kind == OP_PROG) ? wdata : ERASED_BYTE;
    end
  end

  assign rd_status = rd_en && busy &&
                     (kind_q != OP_SECT || rd_sect == sect_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle_q <= 1'b0;
      rdata    <= 8'h00;
    end else begin
      if (start_op)       toggle_q <= 1'b0;
      else if (rd_status) toggle_q <= ~toggle_q;
      if (rd_en)
        rdata <= rd_status ? poll_byte(pend_q, toggle_q) : arr_byte;
    end
  end

  assign ry_by_n = busy ? 1'b0 : 1'bz;

endmodule

// File: rtl/flash_cmd_if_sva.sv
module flash_cmd_if_sva
  import flash_cmd_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_op,
  input op_kind_e         start_kind,
  input logic             wd7,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] remain,
  input logic             rd_status,
  input logic [7:0]       rdata
);

  logic exp7, st_d, seen, prev6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp7 <= 1'b0; st_d <= 1'b0; seen <= 1'b0; prev6 <= 1'b0;
    end else begin
      st_d <= rd_status;
      if (start_op) begin
        exp7 <= (start_kind == OP_PROG) ? ~wd7 : 1'b0;
        seen <= 1'b0;
      end else if (st_d) begin
        seen  <= 1'b1;
        prev6 <= rdata[6];
      end
    end
  end

  a_r3_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_op |=> busy);
  a_r10_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_op);
  a_r3_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && remain == $past(remain) - CNT_W'(1)));
  a_r4_status_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> rdata[5:0] == 6'b0);
  a_r4_status_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    st_d |-> rdata[7] == exp7);
  a_r5_first_toggle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_d && !seen) |-> !rdata[6]);
  a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (st_d && seen) |-> rdata[6] != prev6);

endmodule

bind flash_cmd_if flash_cmd_if_sva #(.CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_op   (start_op),
  .start_kind (start_kind),
  .wd7        (wdata[7]),
  .busy       (busy),
  .done       (done),
  .remain     (remain),
  .rd_status  (rd_status),
  .rdata      (rdata)
);

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;

  localparam int PROG_N = 8;
  localparam int SECT_N = 20;
  localparam int CHIP_N = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  wire         ry_line;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  pullup (ry_line);

  always #2 clk = ~clk;

  flash_cmd_if #(.PROG_CYCLES(PROG_N), .SECT_CYCLES(SECT_N),
                 .CHIP_CYCLES(CHIP_N)) u_flash_cmd_if (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ry_by_n(ry_line)
  );

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (ry_line == 1'b0 && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic program_seq(input logic [15:0] a, input logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_seq(input logic [15:0] a, input logic [7:0] last);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(a, last);
  endtask

  task automatic t_reset;
    check("R1 ready after reset", int'(ry_line), 1);
    check("R1 rdata after reset", int'(rdata), 0);
  endtask

  task automatic t_chip_erase;
    int n; logic [7:0] d;
    erase_seq(16'h5555, 8'h10);
    check("R3 chip erase busy", int'(ry_line), 0);
    count_busy(n);
    check("R3 R7 chip erase length", n, CHIP_N);
    rd(16'h0000, d); check("R7 erased low", int'(d), 8'hFF);
    rd(16'hF803, d); check("R7 erased high", int'(d), 8'hFF);
    rd(16'h1801, d); check("R7 erased mid", int'(d), 8'hFF);
  endtask

  task automatic t_program;
    int n; logic [7:0] d;
    program_seq(16'h1801, 8'h5A);
    rd(16'h1801, d); check("R4 R5 status first", int'(d), 8'h80);
    rd(16'h0002, d); check("R4 R5 status second", int'(d), 8'hC0);
    count_busy(n);
    rd(16'h1801, d); check("R2 R4 programmed", int'(d), 8'h5A);
    program_seq(16'h1801, 8'hF0);
    count_busy(n);
    check("R3 program length", n, PROG_N);
    rd(16'h1801, d); check("R2 AND merge", int'(d), 8'h50);
    program_seq(16'h2002, 8'hC3);
    rd(16'h2002, d); check("R4 status bit7 clear", int'(d), 8'h00);
    count_busy(n);
    rd(16'h2002, d); check("R4 true data after", int'(d), 8'hC3);
  endtask

  task automatic t_sector_erase;
    int n; logic [7:0] d;
    erase_seq(16'h1803, 8'h30);
    rd(16'h2002, d); check("R8 other sector readable", int'(d), 8'hC3);
    rd(16'h1801, d); check("R8 erasing sector status", int'(d), 8'h00);
    rd(16'h1800, d); check("R8 R5 status toggles", int'(d), 8'h40);
    count_busy(n);
    check("R3 sector erase ends", int'(ry_line), 1);
    rd(16'h1801, d); check("R6 sector erased", int'(d), 8'hFF);
    rd(16'h2002, d); check("R6 neighbour kept", int'(d), 8'hC3);
  endtask

  task automatic t_broken;
    int n; logic [7:0] d;
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h1234, 8'hA0);
    wr(16'h0801, 8'h00);
    check("R9 no operation started", int'(ry_line), 1);
    rd(16'h0801, d); check("R9 array untouched", int'(d), 8'hFF);
    program_seq(16'h0801, 8'h3C);
    count_busy(n);
    rd(16'h0801, d); check("R9 recovery program", int'(d), 8'h3C);
  endtask

  task automatic t_busy_writes;
    int n; logic [7:0] d;
    program_seq(16'h3000, 8'h11);
    program_seq(16'h3001, 8'h00);
    count_busy(n);
    rd(16'h3001, d); check("R10 ignored while busy", int'(d), 8'hFF);
    rd(16'h3000, d); check("R10 first op done", int'(d), 8'h11);
    check("R10 no second op", int'(ry_line), 1);
  endtask

  task automatic t_reset_abort;
    int n; logic [7:0] d;
    program_seq(16'h4002, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R11 released by reset", int'(ry_line), 1);
    rd(16'h4002, d); check("R11 target unchanged", int'(d), 8'hFF);
    program_seq(16'h4002, 8'h81);
    count_busy(n);
    rd(16'h4002, d); check("R11 read mode after abort", int'(d), 8'h81);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chip_erase();
    t_program();
    t_sector_erase();
    t_broken();
    t_busy_writes();
    t_reset_abort();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule